// File: doc/BRIEF.md
# Multiply-Divide Arithmetic-Logic Unit

This block is the arithmetic core of a small load/store processor datapath. It is purely combinational. It takes two 32-bit operands and a 5-bit operation code taken from the top of the instruction word, and returns a 64-bit result split into a low word and a high word. Operand A normally comes from the operand holding register and operand B from the internal bus. The low word feeds the low half of the result register. The high word feeds its upper half, from which multiply and divide results are moved into the HI/LO pair.

Single-word operations are add, subtract, bitwise and/or, negate and invert, logical shifts and rotates. They fill only the low word and drive the high word to zero. Multiply and divide are signed two's complement operations and use both words. Shift and rotate amounts come from the low five bits of operand B, so a variable count can be supplied from any register. Negate and invert work on operand B alone.

There is no clock, no state and no handshake. Results settle in the same cycle as the inputs, and the surrounding control sequencer decides when to capture them.

Top module: `mdalu`

## Requirements
- R1: Opcode 00011 (add) gives result_lo = (A + B) mod 2^32, for example 0xFFFFFFFF + 1 = 0.
- R2: Opcode 00100 (subtract) gives result_lo = (A − B) mod 2^32.
- R3: Opcode 01001 gives result_lo = A AND B, and opcode 01010 gives A OR B.
- R4: Opcode 10000 (negate) gives the two's complement of B, so 0x59 becomes 0xFFFFFFA7. Opcode 10001 (invert) gives ~B, so 0xFFFFFFA7 becomes 0x58. A has no effect on either.
- R5: Opcode 00101 shifts A logically right and opcode 00110 shifts A logically left, both by B[4:0]. Bits B[31:5] are ignored. Examples: 0xCC right by 1 is 0x66, and 0xCD left by 1 is 0x19A.
- R6: Opcode 00111 rotates A right and opcode 01000 rotates A left, both by B[4:0]. Rotating right moves bit 0 into bit 31. Examples: 0x34 rotated right by 1 is 0x1A, and 0x66 rotated left by 1 is 0xCC.
- R7: Opcode 01110 (multiply) gives the signed 64-bit product of A and B, with {result_hi, result_lo} = A × B. For example, 5 × 0x1D gives hi 0 and lo 0x91.
- R8: Opcode 01111 (divide) with B ≠ 0 puts the signed quotient A / B, truncated toward zero, in result_lo. It puts the remainder in result_hi, and the remainder takes the sign of A. For example, 0x1D / 5 gives lo 5 and hi 4.
- R9: Divide with B = 0 gives result_lo = 0xFFFFFFFF and result_hi = A. No other indication is raised.
- R10: Divide of 0x80000000 by 0xFFFFFFFF wraps to result_lo = 0x80000000 and result_hi = 0.
- R11: Every opcode other than 01110 and 01111 drives result_hi to 0. Opcodes that no operation uses drive both words to 0.
- R12: Outputs depend only on the present inputs. A result is valid in the same cycle its inputs are applied, and earlier operations leave no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 5 | Operation code from instruction bits 31..27 |
| opnd_a | input | 32 | Operand A, from the holding register |
| opnd_b | input | 32 | Operand B, from the bus; also supplies the shift count |
| result_lo | output | 32 | Low result word; the quotient on divide |
| result_hi | output | 32 | High result word; the remainder on divide, otherwise zero or the product's upper half |

## Verification
The hardest conditions to reach from the ports are the divide corners. These are division by zero, the most-negative value divided by minus one, and mixed-sign operands where truncation and the sign of the remainder matter. Count operands with bits above bit 4 set are equally rare under random stimulus. The bench therefore crosses every one of the 32 opcodes with a grid of hand-picked operands (0, 1, 2, 31, 32, 33, all-ones, minus two, most-negative, most-positive and a few mid values) on both inputs. It then adds random operand pairs for each opcode. Every result is compared with a 64-bit arithmetic model in the bench.

// File: rtl/mdalu_pkg.sv
`timescale 1ns/1ps
package mdalu_pkg;

  localparam int unsigned OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD = 5'b00011,
    OPC_SUB = 5'b00100,
    OPC_SHR = 5'b00101,
    OPC_SHL = 5'b00110,
    OPC_ROR = 5'b00111,
    OPC_ROL = 5'b01000,
    OPC_AND = 5'b01001,
    OPC_OR  = 5'b01010,
    OPC_MUL = 5'b01110,
    OPC_DIV = 5'b01111,
    OPC_NEG = 5'b10000,
    OPC_NOT = 5'b10001
  } opc_e;

  typedef enum logic [1:0] {
    BW_AND,
    BW_OR,
    BW_NOT
  } bw_mode_e;

  typedef enum logic [2:0] {
    PICK_NONE,
    PICK_ARITH,
    PICK_LOGIC,
    PICK_SHIFT,
    PICK_MULDIV
  } pick_e;

endpackage

// File: rtl/mdalu_addsub.sv
`timescale 1ns/1ps
module mdalu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  input  logic         do_neg,
  output logic [W-1:0] sum
);

  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic         cin;

  always_comb begin
    lhs = do_neg ? {W{1'b0}} : a;
    rhs = (do_sub || do_neg) ? ~b : b;
    cin = do_sub || do_neg;
    sum = lhs + rhs + {{(W-1){1'b0}}, cin};
  end

  // Inverse checks on the adder output
  logic [W-1:0] back_sum;
  always_comb begin
    back_sum = sum + b;
    if (!$isunknown({a, b, do_sub, do_neg})) begin
      if (do_sub && !do_neg) begin
        a_r2_sub_inverse: assert (back_sum == a)
          else $error("R2 difference plus B does not restore A");
      end
      if (do_neg) begin
        a_r4_neg_cancels: assert (back_sum == {W{1'b0}})
          else $error("R4 negation plus B is not zero");
      end
    end
  end

endmodule

// File: rtl/mdalu_bitwise.sv
`timescale 1ns/1ps
module mdalu_bitwise
  import mdalu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  bw_mode_e     mode,
  output logic [W-1:0] out
);

  always_comb begin
    unique case (mode)
      BW_AND:  out = a & b;
      BW_OR:   out = a | b;
      BW_NOT:  out = ~b;
      default: out = {W{1'b0}};
    endcase
  end

  always_comb begin
    if (!$isunknown({b, mode}) && mode == BW_NOT) begin
      a_r4_not_disjoint: assert (((out & b) == {W{1'b0}}) && ((out | b) == {W{1'b1}}))
        else $error("R4 inversion does not complement B");
    end
  end

endmodule

// File: rtl/mdalu_shifter.sv
`timescale 1ns/1ps
module mdalu_shifter #(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    value,
  input  logic [SH_W-1:0] amount,
  input  logic            left,
  input  logic            rotate,
  output logic [W-1:0]    out
);

  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = value;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned D = 1 << k;
    logic [D-1:0] wrap_l;
    logic [D-1:0] wrap_r;
    logic [W-1:0] moved;

    assign wrap_l = rotate ? stage[k][W-1 -: D] : {D{1'b0}};
    assign wrap_r = rotate ? stage[k][D-1:0]    : {D{1'b0}};
    assign moved  = left ? {stage[k][W-D-1:0], wrap_l}
                         : {wrap_r, stage[k][W-1:D]};
    assign stage[k+1] = amount[k] ? moved : stage[k];
  end

  assign out = stage[SH_W];

  always_comb begin
    if (!$isunknown({value, amount, left, rotate}) && rotate) begin
      a_r6_rot_keeps_ones: assert ($countones(out) == $countones(value))
        else $error("R6 rotation changed the number of set bits");
    end
  end

endmodule

// File: rtl/mdalu_muldiv.sv
`timescale 1ns/1ps
module mdalu_muldiv #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           is_div,
  output logic [2*W-1:0] res
);

  localparam int unsigned P = 2 * W;

  logic signed [P-1:0] ext_a;
  logic signed [P-1:0] ext_b;
  logic signed [P-1:0] prod;

  logic [W-1:0] mag_a;
  logic [W-1:0] mag_b;
  logic [W-1:0] div_by;
  logic [W-1:0] q_mag;
  logic [W-1:0] r_mag;
  logic [W-1:0] quo;
  logic [W-1:0] rem;
  logic         b_zero;

  always_comb begin
    ext_a = {{W{a[W-1]}}, a};
    ext_b = {{W{b[W-1]}}, b};
    prod  = ext_a * ext_b;
  end

  always_comb begin
    b_zero = (b == {W{1'b0}});
    mag_a  = a[W-1] ? (~a + 1'b1) : a;
    mag_b  = b[W-1] ? (~b + 1'b1) : b;
    div_by = b_zero ? {{(W-1){1'b0}}, 1'b1} : mag_b;
    q_mag  = mag_a / div_by;
    r_mag  = mag_a % div_by;
    if (b_zero) begin
      quo = {W{1'b1}};
      rem = a;
    end else begin
      quo = (a[W-1] ^ b[W-1]) ? (~q_mag + 1'b1) : q_mag;
      rem = a[W-1] ? (~r_mag + 1'b1) : r_mag;
    end
  end

  assign res = is_div ? {rem, quo} : prod;

  // Checks relate the packed outputs back to the operands
  logic [W-1:0] rebuilt;
  logic [W-1:0] hi_mag;
  always_comb begin
    rebuilt = res[W-1:0] * b + res[P-1:W];
    hi_mag  = res[P-1] ? (~res[P-1:W] + 1'b1) : res[P-1:W];
    if (!$isunknown({a, b, is_div})) begin
      if (is_div && !b_zero) begin
        a_r8_div_identity: assert (rebuilt == a)
          else $error("R8 quotient times divisor plus remainder differs from dividend");
        a_r8_rem_bound: assert (hi_mag < mag_b)
          else $error("R8 remainder magnitude not below divisor magnitude");
      end
      if (!is_div && b == {{(W-1){1'b0}}, 1'b1}) begin
        a_r7_mul_by_one: assert (res == ext_a)
          else $error("R7 product by one is not the sign-extended operand");
      end
    end
  end

endmodule

// File: rtl/mdalu.sv
`timescale 1ns/1ps
module mdalu
  import mdalu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [4:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result_lo,
  output logic [W-1:0] result_hi
);

  localparam int unsigned SH_W = $clog2(W);

  logic     as_sub;
  logic     as_neg;
  bw_mode_e bw_mode;
  logic     sh_left;
  logic     sh_rot;
  logic     md_div;
  pick_e    pick;

  always_comb begin
    as_sub  = 1'b0;
    as_neg  = 1'b0;
    bw_mode = BW_AND;
    sh_left = 1'b0;
    sh_rot  = 1'b0;
    md_div  = 1'b0;
    pick    = PICK_NONE;
    case (op_code)
      OPC_ADD: pick = PICK_ARITH;
      OPC_SUB: begin pick = PICK_ARITH; as_sub = 1'b1; end
      OPC_NEG: begin pick = PICK_ARITH; as_neg = 1'b1; end
      OPC_AND: begin pick = PICK_LOGIC; bw_mode = BW_AND; end
      OPC_OR:  begin pick = PICK_LOGIC; bw_mode = BW_OR; end
      OPC_NOT: begin pick = PICK_LOGIC; bw_mode = BW_NOT; end
      OPC_SHR: pick = PICK_SHIFT;
      OPC_SHL: begin pick = PICK_SHIFT; sh_left = 1'b1; end
      OPC_ROR: begin pick = PICK_SHIFT; sh_rot = 1'b1; end
      OPC_ROL: begin pick = PICK_SHIFT; sh_rot = 1'b1; sh_left = 1'b1; end
      OPC_MUL: pick = PICK_MULDIV;
      OPC_DIV: begin pick = PICK_MULDIV; md_div = 1'b1; end
      default: pick = PICK_NONE;
    endcase
  end

  logic [W-1:0]   arith_out;
  logic [W-1:0]   logic_out;
  logic [W-1:0]   shift_out;
  logic [2*W-1:0] md_out;

  mdalu_addsub #(.W(W)) u_addsub (
    .a      (opnd_a),
    .b      (opnd_b),
    .do_sub (as_sub),
    .do_neg (as_neg),
    .sum    (arith_out)
  );

  mdalu_bitwise #(.W(W)) u_bitwise (
    .a    (opnd_a),
    .b    (opnd_b),
    .mode (bw_mode),
    .out  (logic_out)
  );

  mdalu_shifter #(.W(W), .SH_W(SH_W)) u_shifter (
    .value  (opnd_a),
    .amount (opnd_b[SH_W-1:0]),
    .left   (sh_left),
    .rotate (sh_rot),
    .out    (shift_out)
  );

  mdalu_muldiv #(.W(W)) u_muldiv (
    .a      (opnd_a),
    .b      (opnd_b),
    .is_div (md_div),
    .res    (md_out)
  );

  always_comb begin
    result_hi = {W{1'b0}};
    result_lo = {W{1'b0}};
    case (pick)
      PICK_ARITH:  result_lo = arith_out;
      PICK_LOGIC:  result_lo = logic_out;
      PICK_SHIFT:  result_lo = shift_out;
      PICK_MULDIV: {result_hi, result_lo} = md_out;
      default:     ;
    endcase
  end

endmodule

// File: tb/mdalu_test.sv
`timescale 1ns/1ps
module mdalu_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  op;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] lo;
  logic [31:0] hi;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mdalu uut (
    .op_code   (op),
    .opnd_a    (a),
    .opnd_b    (b),
    .result_lo (lo),
    .result_hi (hi)
  );

  function automatic logic [63:0] model(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] r;
    int n;
    longint sx, sy, q, m;
    r  = '0;
    n  = int'(y[4:0]);
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (o)
      5'b00011: return {32'h0, x + y};
      5'b00100: return {32'h0, x - y};
      5'b01001: return {32'h0, x & y};
      5'b01010: return {32'h0, x | y};
      5'b10000: return {32'h0, 32'h0 - y};
      5'b10001: return {32'h0, 32'hFFFFFFFF ^ y};
      5'b00101: begin for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? x[i+n] : 1'b0; return {32'h0, r}; end
      5'b00110: begin for (int i = 0; i < 32; i++) r[i] = (i >= n) ? x[i-n] : 1'b0; return {32'h0, r}; end
      5'b00111: begin for (int i = 0; i < 32; i++) r[i] = x[(i + n) % 32]; return {32'h0, r}; end
      5'b01000: begin for (int i = 0; i < 32; i++) r[i] = x[(i - n + 32) % 32]; return {32'h0, r}; end
      5'b01110: begin q = sx * sy; return q; end
      5'b01111: begin
        if (y == 32'h0) return {x, 32'hFFFFFFFF};
        q = sx / sy;
        m = sx % sy;
        return {m[31:0], q[31:0]};
      end
      default: return 64'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      5'b00011: return "R1";
      5'b00100: return "R2";
      5'b01001, 5'b01010: return "R3";
      5'b10000, 5'b10001: return "R4";
      5'b00101, 5'b00110: return "R5";
      5'b00111, 5'b01000: return "R6";
      5'b01110: return "R7";
      5'b01111: begin
        if (y == 32'h0) return "R9";
        if (x == 32'h80000000 && y == 32'hFFFFFFFF) return "R10";
        return "R8";
      end
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [63:0] exp, input string tag);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    checks++;
    if ({hi, lo} !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, o, x, y, {hi, lo}, exp);
    end
  endtask

  task automatic auto(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
    run(o, x, y, model(o, x, y), tag_of(o, x, y));
  endtask

  localparam int NC = 14;
  localparam logic [31:0] CORN [NC] = '{
    32'h0, 32'h1, 32'h2, 32'h1F, 32'h20, 32'h21, 32'h5, 32'h1D,
    32'h59, 32'hCC, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFE
  };

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op = 5'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    // R11 R12: idle inputs give zero outputs, with no settling delay
    run(5'b00000, 32'h0, 32'h0, 64'h0, "R12");
    rst_n = 1'b1;

    run(5'b01110, 32'h5, 32'h1D, {32'h0, 32'h91}, "R7");
    run(5'b01111, 32'h1D, 32'h5, {32'h4, 32'h5}, "R8");
    run(5'b01111, 32'hFFFFFFF9, 32'h2, {32'hFFFFFFFF, 32'hFFFFFFFD}, "R8");
    run(5'b01111, 32'h1234, 32'h0, {32'h1234, 32'hFFFFFFFF}, "R9");
    run(5'b01111, 32'h80000000, 32'hFFFFFFFF, {32'h0, 32'h80000000}, "R10");
    run(5'b10000, 32'h12345678, 32'h59, {32'h0, 32'hFFFFFFA7}, "R4");
    run(5'b10001, 32'hABCDEF01, 32'hFFFFFFA7, {32'h0, 32'h58}, "R4");
    run(5'b00111, 32'h34, 32'h1, {32'h0, 32'h1A}, "R6");
    run(5'b01000, 32'h66, 32'h1, {32'h0, 32'hCC}, "R6");
    run(5'b00101, 32'hCC, 32'h1, {32'h0, 32'h66}, "R5");
    run(5'b00110, 32'hCD, 32'h1, {32'h0, 32'h19A}, "R5");
    run(5'b00101, 32'hCC, 32'hFFFFFFE1, {32'h0, 32'h66}, "R5");
    run(5'b00011, 32'hFFFFFFFF, 32'h1, 64'h0, "R1");
    run(5'b00100, 32'h0, 32'h1, {32'h0, 32'hFFFFFFFF}, "R2");
    run(5'b01001, 32'hF0F0, 32'h0FF0, {32'h0, 32'h00F0}, "R3");
    run(5'b01010, 32'hF0F0, 32'h0FF0, {32'h0, 32'hFFF0}, "R3");
    // R12: after a wide result, a single-word op shows no residue
    run(5'b01110, 32'hFFFFFFFF, 32'h80000000, {32'h0, 32'h80000000}, "R7");
    run(5'b00011, 32'h2, 32'h3, {32'h0, 32'h5}, "R12");

    for (int o = 0; o < 32; o++)
      for (int i = 0; i < NC; i++)
        for (int j = 0; j < NC; j++)
          auto(o[4:0], CORN[i], CORN[j]);

    for (int o = 0; o < 32; o++)
      for (int k = 0; k < 64; k++)
        auto(o[4:0], $urandom, (k % 4 == 0) ? ($urandom % 64) : $urandom);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule